// File: doc/BRIEF.md
# Two-Channel Rectifier Driver Power-Up Sequencer

This block steps the enables of a two-channel synchronous rectifier gate driver through its power-up states as the internal logic supply rises. Two digitised comparator flags, each already carrying its own hysteresis, report whether the logic supply is above the chip-level lockout and above the main lockout. The main lockout trips at roughly nine tenths of the final supply. Both flags are resynchronised and then drive a three-state sequence: standby, logic-only and run.

In standby, everything is held off and the error-amplifier output is clamped low. In logic-only, the internal logic is enabled and the amplifier clamp is released. The reference stays clamped to zero, and both main drivers stay disabled. In run, the reference clamp is released, both drivers are enabled, and each gate command follows its own timing input without inversion.

Until run is reached, each channel's hold-off pull-down switch is steered by the opposite channel's timing input. While one primary pulse is present, the other rectifier gate is therefore held low. When either flag drops, the sequence falls back to the matching lower state. The flags are control pins with no handshake, and the timing inputs pass straight to the gate and hold-off commands.

Top module: `sr_powerup_seq`

## Requirements
- R1: After reset the block is in standby: logic_en=0, ea_clamp=1, ref_clamp=1, drv_en_a=drv_en_b=0, out_a=out_b=0.
- R2: Each flag passes through two synchroniser flip-flops. A flag change held at the input takes effect on the outputs after the third rising clock edge, counted from its application, and not after the second.
- R3: In logic-only state the outputs are logic_en=1, ea_clamp=0, ref_clamp=1, drv_en_a=drv_en_b=0.
- R4: Run is entered only from logic-only. If both flags rise together, logic-only holds for exactly one cycle before run.
- R5: In run state the outputs are ref_clamp=0, drv_en_a=drv_en_b=1, hold_a=hold_b=0, out_a=in_a and out_b=in_b.
- R6: Outside run state, out_a=out_b=0, hold_a=in_b and hold_b=in_a. This swap applies in both standby and logic-only.
- R7: When main_ok deasserts in run while chip_ok stays high, the block returns to logic-only. The change is seen after the third rising edge.
- R8: When chip_ok deasserts, the block returns to standby from any state.
- R9: main_ok has no effect while chip_ok is low: the outputs stay in the standby values of R1.
- R10: On each channel, the main driver enable and the hold-off switch are never both on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_ok | input | 1 | Logic supply above chip lockout (hysteresis upstream) |
| main_ok | input | 1 | Logic supply above main lockout (hysteresis upstream) |
| in_a | input | 1 | Timing input, channel A |
| in_b | input | 1 | Timing input, channel B |
| logic_en | output | 1 | Internal logic enable |
| ea_clamp | output | 1 | Clamp error-amplifier output low |
| ref_clamp | output | 1 | Hold reference at zero |
| drv_en_a | output | 1 | Main driver enable, channel A |
| drv_en_b | output | 1 | Main driver enable, channel B |
| out_a | output | 1 | Gate command, channel A |
| out_b | output | 1 | Gate command, channel B |
| hold_a | output | 1 | Hold-off pull-down command on channel A output |
| hold_b | output | 1 | Hold-off pull-down command on channel B output |

## Verification
The bench targets these corner cases:
- Both flags rising on the same edge. A design that skips logic-only would enable the drivers while the reference is still clamped.
- main_ok rising alone. A design that ignores chip_ok would leave standby early.
- Flag timing at the edge before the expected change and at the edge of the change. This catches a synchroniser that is one stage short or one stage long.
- Each input pattern in every state. A design that steers each hold-off from its own input, or that keeps hold-off active in run, would pull a gate low while its driver is on.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_LOGIC   = 2'd1,
    ST_RUN     = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sr_flag_sync.sv
module sr_flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_ok_s,
  input  logic       main_ok_s,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_STANDBY: if (chip_ok_s) nxt = ST_LOGIC;
      ST_LOGIC: begin
        if (!chip_ok_s)     nxt = ST_STANDBY;
        else if (main_ok_s) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (!chip_ok_s)      nxt = ST_STANDBY;
        else if (!main_ok_s) nxt = ST_LOGIC;
      end
      default: nxt = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_STANDBY;
    else        state <= nxt;
  end
endmodule

// File: rtl/sr_holdoff_steer.sv
module sr_holdoff_steer #(
  parameter int NUM_CH = 2
) (
  input  logic              run,
  input  logic [NUM_CH-1:0] timing,
  output logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] hold
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PARTNER = NUM_CH - 1 - c;
    // main path passes its own input, hold-off takes the partner's
    assign gate[c] = run & timing[c];
    assign hold[c] = ~run & timing[PARTNER];
  end
endmodule

// File: rtl/sr_powerup_seq.sv
module sr_powerup_seq
  import sr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_ok,
  input  logic main_ok,
  input  logic in_a,
  input  logic in_b,
  output logic logic_en,
  output logic ea_clamp,
  output logic ref_clamp,
  output logic drv_en_a,
  output logic drv_en_b,
  output logic out_a,
  output logic out_b,
  output logic hold_a,
  output logic hold_b
);
  localparam int NUM_FLAGS = 2;
  localparam int NUM_CH    = 2;

  logic [NUM_FLAGS-1:0] flags_s;
  seq_state_t           state;
  logic                 run;
  logic [NUM_CH-1:0]    gate, hold;

  sr_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({main_ok, chip_ok}),
    .q     (flags_s)
  );

  sr_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_ok_s (flags_s[0]),
    .main_ok_s (flags_s[1]),
    .state     (state)
  );

  assign run = (state == ST_RUN);

  sr_holdoff_steer #(.NUM_CH(NUM_CH)) u_steer (
    .run    (run),
    .timing ({in_b, in_a}),
    .gate   (gate),
    .hold   (hold)
  );

  assign logic_en  = (state != ST_STANDBY);
  assign ea_clamp  = (state == ST_STANDBY);
  assign ref_clamp = ~run;
  assign drv_en_a  = run;
  assign drv_en_b  = run;
  assign out_a     = gate[0];
  assign out_b     = gate[1];
  assign hold_a    = hold[0];
  assign hold_b    = hold[1];
endmodule

// File: rtl/sr_powerup_seq_chk.sv
module sr_powerup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_a,
  input logic in_b,
  input logic logic_en,
  input logic ea_clamp,
  input logic ref_clamp,
  input logic drv_en_a,
  input logic drv_en_b,
  input logic out_a,
  input logic out_b,
  input logic hold_a,
  input logic hold_b
);
  // R10
  no_overlap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en_a && hold_a));

  // R10
  no_overlap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en_b && hold_b));

  // R4
  run_from_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en_a) |-> $past(logic_en) && !$past(drv_en_a));

  // R5
  ref_free_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clamp |-> (!hold_a && !hold_b && drv_en_a && drv_en_b));

  // R1
  standby_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_clamp |-> (!logic_en && ref_clamp && !out_a && !out_b));

  // R6
  swap_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clamp |-> (!out_a && !out_b));
endmodule

bind sr_powerup_seq sr_powerup_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_a      (in_a),
  .in_b      (in_b),
  .logic_en  (logic_en),
  .ea_clamp  (ea_clamp),
  .ref_clamp (ref_clamp),
  .drv_en_a  (drv_en_a),
  .drv_en_b  (drv_en_b),
  .out_a     (out_a),
  .out_b     (out_b),
  .hold_a    (hold_a),
  .hold_b    (hold_b)
);

// File: tb/test_sr_powerup_seq.sv
`timescale 1ns/1ps
module test_sr_powerup_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_ok = 1'b0, main_ok = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic logic_en, ea_clamp, ref_clamp, drv_en_a, drv_en_b;
  logic out_a, out_b, hold_a, hold_b;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sr_powerup_seq i_sr_powerup_seq (
    .clk(clk), .rst_n(rst_n), .chip_ok(chip_ok), .main_ok(main_ok),
    .in_a(in_a), .in_b(in_b), .logic_en(logic_en), .ea_clamp(ea_clamp),
    .ref_clamp(ref_clamp), .drv_en_a(drv_en_a), .drv_en_b(drv_en_b),
    .out_a(out_a), .out_b(out_b), .hold_a(hold_a), .hold_b(hold_b)
  );

  // {chip, main, in_a, in_b, logic_en, ea_clamp, ref_clamp, drv_a, drv_b, out_a, out_b, hold_a, hold_b}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    13'b00_10_011_00_00_01,  // R1 R6 standby swap
    13'b00_01_011_00_00_10,  // R6 standby swap
    13'b01_11_011_00_00_11,  // R9 main alone ignored
    13'b10_10_101_00_00_01,  // R3 R6 logic-only
    13'b10_01_101_00_00_10,  // R3 R6
    13'b10_00_101_00_00_00,  // R3
    13'b11_10_100_11_10_00,  // R5 run
    13'b11_01_100_11_01_00,  // R5
    13'b11_11_100_11_11_00,  // R5
    13'b10_11_101_00_00_11,  // R7 back to logic-only
    13'b11_00_100_11_00_00,  // R5
    13'b01_01_011_00_00_10   // R8 chip drop to standby
  };

  function automatic logic [8:0] outs();
    return {logic_en, ea_clamp, ref_clamp, drv_en_a, drv_en_b, out_a, out_b, hold_a, hold_b};
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  // R10 continuous monitor
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if ((drv_en_a && hold_a) || (drv_en_b && hold_b)) begin
      fails++;
      $display("FAIL R10: drv=%b%b hold=%b%b expected no overlap",
               drv_en_a, drv_en_b, hold_a, hold_b);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1", 9'b011_00_00_00);
    @(negedge clk); rst_n = 1'b1;
    edges(3);
    check("R1", 9'b011_00_00_00);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {chip_ok, main_ok, in_a, in_b} = VEC[v][12:9];
      edges(5);
      @(negedge clk);
      check($sformatf("vector%0d", v), VEC[v][8:0]);
    end

    // R2 R4: both flags rise together from standby
    @(negedge clk); chip_ok = 0; main_ok = 0; in_a = 0; in_b = 0;
    edges(5);
    @(negedge clk); chip_ok = 1; main_ok = 1;
    edges(2); check("R2", 9'b011_00_00_00);
    edges(1); check("R4", 9'b101_00_00_00);
    edges(1); check("R4", 9'b100_11_00_00);

    // R7 timing of main drop
    @(negedge clk); main_ok = 0; in_a = 1;
    edges(2); check("R7", 9'b100_11_10_00);
    edges(1); check("R7", 9'b101_00_00_01);

    // R8 chip drop from run with latency
    @(negedge clk); main_ok = 1; in_a = 0;
    edges(5);
    @(negedge clk); chip_ok = 0; in_b = 1;
    edges(2); check("R8", 9'b100_11_01_00);
    edges(1); check("R8", 9'b011_00_00_10);

    // R1 reset mid-run returns to standby
    @(negedge clk); chip_ok = 1; in_b = 0;
    edges(6);
    @(negedge clk); rst_n = 0; #1;
    check("R1", 9'b011_00_00_00);
    @(negedge clk); rst_n = 1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule